// File: doc/BRIEF.md
# Serial Management Register Slave

This block answers a host on the two-wire management bus (clock MDC, bidirectional data MDIO). It parses clause-22 frames, compares the frame's five-bit station address with its own, and on a match either writes a register or drives the requested register back onto the data line. The station address comes from strap inputs and is captured while reset is held. MDC and MDIO are oversampled by the block's own fast clock through synchronizers, so the slave runs in one clock domain. A frame may start at any time while the line is idle-high. A full 32-bit run of ones before the start pattern is accepted but not needed, so frames may follow each other back to back.

The register bank holds a control register, a constant status register, an advertisement register, an interrupt register and a vendor register that holds the interrupt polarity. Every other address reads as zero and ignores writes. Three event strobes (link down, remote fault, partner acknowledge) latch into sticky status bits. Reading the interrupt register returns those bits and clears them. The interrupt pin is active whenever a latched bit has its enable set, and its active level is programmable. The management bus is a serial, bit-timed protocol with no back-pressure, so no valid/ready handshake applies here. All pins are plain control and data.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset, register 0 reads 0x3100, register 4 reads 0x01E1 (selector field bits 4:0 = 00001, bit 5 = 1), and registers 0x1B and 0x1F read 0. MDIO is not driven, and the interrupt pin is high (active-low polarity, nothing pending).
- R2: Register 1 always reads 0x7849, with bit 6 (preamble may be omitted) set. Writes to it leave it unchanged.
- R3: A frame is the start bits 0 then 1, an opcode (10 read, 01 write), a 5-bit station address, a 5-bit register address, two turnaround bits and 16 data bits, MSB first, each sampled on a rising MDC. Frames are decoded both with a 32-bit preamble of ones and with none at all.
- R4: The station address is taken from the strap pins while reset is low. Changes on the straps after reset is released have no effect.
- R5: A frame with a different station address or with opcode 00 or 11 never drives MDIO and changes no register.
- R6: On a matching read, MDIO stays released through the first turnaround bit and is driven 0 in the second. The 16 data bits follow MSB first, and the line is released after the last bit.
- R7: Writes load registers 0 and 4 in full. In register 0x1B only bits 11:9 are writable. In register 0x1F only bit 9 is writable. Unmapped addresses (for example 7) read 0.
- R8: In register 0x1B, bit 3 (partner acknowledge), bit 2 (link down) and bit 1 (remote fault) are set by their strobes. A read returns the latched value and then clears them. An event in the same cycle as the clear stays set.
- R9: The interrupt is pending when any status bit in 0x1B is set while its enable (bit 11 for bit 3, bit 10 for bit 2, bit 9 for bit 1) is set. Register 0x1F bit 9 = 1 makes the pin active high, and 0 makes it active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, at least 4x the MDC rate |
| rst_n | input | 1 | Active-low reset; straps are captured while low |
| strap_phy_addr | input | 5 | Station address strap inputs |
| mdc | input | 1 | Management clock from the host |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data value driven by the slave |
| mdio_oe | output | 1 | Output enable for the data line pad |
| ev_link_down | input | 1 | Link-down event strobe, one clk wide |
| ev_remote_fault | input | 1 | Remote-fault event strobe |
| ev_lp_ack | input | 1 | Partner-acknowledge event strobe |
| irq | output | 1 | Interrupt output, polarity from register 0x1F bit 9 |

## Verification
The bench builds the block with its default parameters: 16-bit registers, 5-bit addresses, two synchronizer stages and the default reset constants. The straps are set to 0x0B. MDC runs at eight block clocks per bit, which leaves the two-stage synchronizer and the output register well inside a half period. The turnaround, the MSB-first data order and the release after the last bit are therefore all visible at the host's sampling points. Back-to-back frames without preamble, strap changes after reset and every interrupt polarity and enable combination are within reach at these values.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HDR,
    ST_TA,
    ST_DATA,
    ST_SKIP
  } mdio_st_e;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  localparam logic [4:0] RA_CTRL = 5'h00;
  localparam logic [4:0] RA_STAT = 5'h01;
  localparam logic [4:0] RA_ADV  = 5'h04;
  localparam logic [4:0] RA_IRQ  = 5'h1B;
  localparam logic [4:0] RA_VEND = 5'h1F;

  localparam int IRQ_N   = 3;
  localparam int ST_LSB  = 1;
  localparam int EN_LSB  = 9;
  localparam int POL_BIT = 9;
endpackage

// File: rtl/mdio_sync_edge.sv
module mdio_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdio_i,
  output logic rise,
  output logic bit_d
);
  logic [STAGES:0]   mdc_sh;
  logic [STAGES-1:0] dio_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_sh <= '0;
      dio_sh <= '1;
    end else begin
      mdc_sh <= {mdc_sh[STAGES-1:0], mdc};
      dio_sh <= {dio_sh[STAGES-2:0], mdio_i};
    end
  end

  assign rise  = mdc_sh[STAGES-1] & ~mdc_sh[STAGES];
  assign bit_d = dio_sh[STAGES-1];
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_pkg::*;
#(
  parameter int PHY_AW = 5,
  parameter int REG_AW = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              bit_d,
  input  logic [PHY_AW-1:0] phy_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic [REG_AW-1:0] reg_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int HDR_BITS = 2 + PHY_AW + REG_AW;
  localparam int CNT_W    = $clog2(DATA_W + 2) + 1;
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] SKIP_LAST = CNT_W'(DATA_W + 1);

  mdio_st_e            st;
  logic [CNT_W-1:0]    cnt;
  logic [HDR_BITS-1:0] hdr;
  logic [DATA_W-1:0]   sh;
  logic                is_rd;
  logic [REG_AW-1:0]   ra_q;

  logic [HDR_BITS-1:0] hdr_full;
  logic [1:0]          f_op;
  logic [PHY_AW-1:0]   f_phy;
  logic [REG_AW-1:0]   f_ra;
  logic                f_ok;

  assign hdr_full = {hdr[HDR_BITS-2:0], bit_d};
  assign f_op     = hdr_full[HDR_BITS-1 -: 2];
  assign f_phy    = hdr_full[REG_AW +: PHY_AW];
  assign f_ra     = hdr_full[REG_AW-1:0];
  assign f_ok     = ((f_op == OP_RD) || (f_op == OP_WR)) && (f_phy == phy_addr);

  assign reg_addr = ra_q;
  assign rd_stb   = rise && (st == ST_TA) && (cnt == '0) && is_rd;
  assign wr_stb   = rise && (st == ST_DATA) && (cnt == DATA_LAST) && !is_rd;
  assign wr_data  = {sh[DATA_W-2:0], bit_d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      hdr     <= '0;
      sh      <= '0;
      is_rd   <= 1'b0;
      ra_q    <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (rise) begin
      case (st)
        ST_IDLE: begin
          if (!bit_d) st <= ST_START;
        end
        ST_START: begin
          cnt <= '0;
          st  <= bit_d ? ST_HDR : ST_IDLE;
        end
        ST_HDR: begin
          hdr <= hdr_full;
          if (cnt == HDR_LAST) begin
            cnt  <= '0;
            ra_q <= f_ra;
            if (f_ok) begin
              st    <= ST_TA;
              is_rd <= (f_op == OP_RD);
            end else begin
              st <= ST_SKIP;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TA: begin
          if (cnt == '0) begin
            cnt <= cnt + 1'b1;
            if (is_rd) begin
              mdio_oe <= 1'b1;
              mdio_o  <= 1'b0;
              sh      <= rd_data;
            end
          end else begin
            cnt <= '0;
            st  <= ST_DATA;
            if (is_rd) begin
              mdio_o <= sh[DATA_W-1];
              sh     <= {sh[DATA_W-2:0], 1'b0};
            end
          end
        end
        ST_DATA: begin
          if (is_rd) begin
            if (cnt == DATA_LAST) begin
              mdio_oe <= 1'b0;
              mdio_o  <= 1'b0;
            end else begin
              mdio_o <= sh[DATA_W-1];
              sh     <= {sh[DATA_W-2:0], 1'b0};
            end
          end else begin
            sh <= wr_data;
          end
          if (cnt == DATA_LAST) begin
            cnt <= '0;
            st  <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SKIP: begin
          if (cnt == SKIP_LAST) begin
            cnt <= '0;
            st  <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_regbank.sv
module mdio_regbank
  import mdio_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] CTRL_RST = 16'h3100,
  parameter logic [DATA_W-1:0] ADV_RST  = 16'h01E1,
  parameter logic [DATA_W-1:0] STAT_VAL = 16'h7849
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IRQ_N-1:0]  ev,
  output logic [DATA_W-1:0] rd_data,
  output logic [IRQ_N-1:0]  irq_st,
  output logic [IRQ_N-1:0]  irq_en,
  output logic              irq_pol,
  output logic              irq_pend
);
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] adv_q;
  logic [IRQ_N-1:0]  ien_q;
  logic [IRQ_N-1:0]  ist_q;
  logic              pol_q;
  logic              clr;

  assign clr = rd_stb && (addr == REG_AW'(RA_IRQ));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      adv_q  <= ADV_RST;
      ien_q  <= '0;
      ist_q  <= '0;
      pol_q  <= 1'b0;
    end else begin
      ist_q <= (clr ? '0 : ist_q) | ev;
      if (wr_stb) begin
        case (addr)
          REG_AW'(RA_CTRL): ctrl_q <= wdata;
          REG_AW'(RA_ADV):  adv_q  <= wdata;
          REG_AW'(RA_IRQ):  ien_q  <= wdata[EN_LSB +: IRQ_N];
          REG_AW'(RA_VEND): pol_q  <= wdata[POL_BIT];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      REG_AW'(RA_CTRL): rd_data = ctrl_q;
      REG_AW'(RA_STAT): rd_data = STAT_VAL;
      REG_AW'(RA_ADV):  rd_data = adv_q;
      REG_AW'(RA_IRQ): begin
        rd_data[EN_LSB +: IRQ_N] = ien_q;
        rd_data[ST_LSB +: IRQ_N] = ist_q;
      end
      REG_AW'(RA_VEND): rd_data[POL_BIT] = pol_q;
      default: ;
    endcase
  end

  assign irq_st   = ist_q;
  assign irq_en   = ien_q;
  assign irq_pol  = pol_q;
  assign irq_pend = |(ist_q & ien_q);
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_pkg::*;
#(
  parameter int PHY_AW      = 5,
  parameter int REG_AW      = 5,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] CTRL_RST = 16'h3100,
  parameter logic [DATA_W-1:0] ADV_RST  = 16'h01E1,
  parameter logic [DATA_W-1:0] STAT_VAL = 16'h7849
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHY_AW-1:0] strap_phy_addr,
  input  logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              ev_link_down,
  input  logic              ev_remote_fault,
  input  logic              ev_lp_ack,
  output logic              irq
);
  logic [PHY_AW-1:0] phy_q;
  logic              rise;
  logic              bit_d;
  logic              rd_stb;
  logic              wr_stb;
  logic [REG_AW-1:0] reg_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic [IRQ_N-1:0]  irq_st;
  logic [IRQ_N-1:0]  irq_en;
  logic              irq_pol;
  logic              irq_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) phy_q <= strap_phy_addr;
  end

  mdio_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .mdc    (mdc),
    .mdio_i (mdio_i),
    .rise   (rise),
    .bit_d  (bit_d)
  );

  mdio_frame_fsm #(.PHY_AW(PHY_AW), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (rise),
    .bit_d    (bit_d),
    .phy_addr (phy_q),
    .rd_data  (rd_data),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );

  mdio_regbank #(
    .REG_AW(REG_AW), .DATA_W(DATA_W),
    .CTRL_RST(CTRL_RST), .ADV_RST(ADV_RST), .STAT_VAL(STAT_VAL)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .addr     (reg_addr),
    .wdata    (wr_data),
    .ev       ({ev_lp_ack, ev_link_down, ev_remote_fault}),
    .rd_data  (rd_data),
    .irq_st   (irq_st),
    .irq_en   (irq_en),
    .irq_pol  (irq_pol),
    .irq_pend (irq_pend)
  );

  assign irq = irq_pol ? irq_pend : ~irq_pend;
endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk #(
  parameter int PHY_AW = 5,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PHY_AW-1:0] phy_q,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              ev_link_down,
  input logic              ev_remote_fault,
  input logic              ev_lp_ack,
  input logic              rd_stb,
  input logic [REG_AW-1:0] reg_addr,
  input logic [2:0]        irq_st,
  input logic [2:0]        irq_en,
  input logic              irq_pol,
  input logic              irq
);
  // R4: captured station address never moves once reset is released
  p_strap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(phy_q));

  // R6: first driven bit of a read is the turnaround zero
  p_ta_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  // R8: a link-down strobe is latched in the following cycle
  p_ev_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_link_down |=> irq_st[1]);

  // R8: a read of the interrupt register with no new event leaves status empty
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && reg_addr == REG_AW'(5'h1B) && !ev_link_down && !ev_remote_fault && !ev_lp_ack)
    |=> (irq_st == 3'b000));

  // R9: enabled event with active-high polarity raises the pin next cycle
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_remote_fault && irq_en[0] && irq_pol) |=> irq);
endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk #(.PHY_AW(PHY_AW), .REG_AW(REG_AW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .phy_q           (phy_q),
  .mdio_o          (mdio_o),
  .mdio_oe         (mdio_oe),
  .ev_link_down    (ev_link_down),
  .ev_remote_fault (ev_remote_fault),
  .ev_lp_ack       (ev_lp_ack),
  .rd_stb          (rd_stb),
  .reg_addr        (reg_addr),
  .irq_st          (irq_st),
  .irq_en          (irq_en),
  .irq_pol         (irq_pol),
  .irq             (irq)
);

// File: tb/mdio_mgmt_slave_bench.sv
module mdio_mgmt_slave_bench;
  localparam time CLK_P = 10ns;
  localparam int  HALF  = 4;
  localparam int  LIMIT = 150000;
  localparam logic [4:0] PHY = 5'h0B;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] strap = PHY;
  logic       mdc = 1'b0;
  logic       m_drv = 1'b0;
  logic       m_val = 1'b1;
  logic       line;
  logic       mdio_o, mdio_oe, irq;
  logic       ev_ld = 1'b0, ev_rf = 1'b0, ev_la = 1'b0;
  int         n_chk = 0;
  int         n_err = 0;

  always #(CLK_P/2) clk = ~clk;
  assign line = mdio_oe ? mdio_o : (m_drv ? m_val : 1'b1);

  mdio_mgmt_slave u_mdio_mgmt_slave (
    .clk(clk), .rst_n(rst_n), .strap_phy_addr(strap), .mdc(mdc),
    .mdio_i(line), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .ev_link_down(ev_ld), .ev_remote_fault(ev_rf), .ev_lp_ack(ev_la), .irq(irq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mbit(input logic drv, input logic val, output logic smp, output logic oe_s);
    @(negedge clk); mdc = 1'b0; m_drv = drv; m_val = val;
    repeat (HALF-1) @(negedge clk);
    smp = line; oe_s = mdio_oe;
    @(negedge clk); mdc = 1'b1;
    repeat (HALF-1) @(negedge clk);
  endtask

  task automatic send_hdr(input int pre, input logic [1:0] op, input logic [4:0] phy,
                          input logic [4:0] ra);
    logic s, o;
    logic [13:0] h;
    h = {2'b01, op, phy, ra};
    for (int i = 0; i < pre; i++) mbit(1'b1, 1'b1, s, o);
    for (int i = 13; i >= 0; i--) mbit(1'b1, h[i], s, o);
  endtask

  task automatic mwrite(input int pre, input logic [4:0] phy, input logic [4:0] ra,
                        input logic [15:0] d, input logic [1:0] op = 2'b01);
    logic s, o;
    send_hdr(pre, op, phy, ra);
    mbit(1'b1, 1'b1, s, o);
    mbit(1'b1, 1'b0, s, o);
    for (int i = 15; i >= 0; i--) mbit(1'b1, d[i], s, o);
    m_drv = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic mread(input int pre, input logic [4:0] phy, input logic [4:0] ra,
                       output logic [15:0] d, output logic tim_ok, output logic any_oe);
    logic s, o1, o2, v2, o, all_oe;
    send_hdr(pre, 2'b10, phy, ra);
    mbit(1'b0, 1'b1, s, o1);
    mbit(1'b0, 1'b1, v2, o2);
    all_oe = 1'b1; any_oe = o1 | o2;
    for (int i = 15; i >= 0; i--) begin
      mbit(1'b0, 1'b1, s, o);
      d[i] = s; all_oe &= o; any_oe |= o;
    end
    mbit(1'b0, 1'b1, s, o);
    tim_ok = !o1 && o2 && !v2 && all_oe && !o;
    any_oe |= o;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] ra, input logic [15:0] exp,
                        input int pre = 32);
    logic [15:0] d; logic t, a;
    mread(pre, PHY, ra, d, t, a);
    chk(req, d, exp);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) ev_ld = 1'b1; else if (which == 1) ev_rf = 1'b1; else ev_la = 1'b1;
    @(negedge clk);
    ev_ld = 1'b0; ev_rf = 1'b0; ev_la = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 oe after reset", {15'd0, mdio_oe}, 16'd0);
    chk("R1 irq after reset", {15'd0, irq}, 16'd1);
    rd_chk("R1 ctrl reset", 5'h00, 16'h3100);
    rd_chk("R1 adv reset", 5'h04, 16'h01E1);
    rd_chk("R1 irq reg reset", 5'h1B, 16'h0000);
    rd_chk("R1 vendor reset", 5'h1F, 16'h0000);
  endtask

  task automatic t_status_ro;
    rd_chk("R2 status value", 5'h01, 16'h7849);
    mwrite(32, PHY, 5'h01, 16'h0000);
    rd_chk("R2 status after write", 5'h01, 16'h7849);
  endtask

  task automatic t_read_timing;
    logic [15:0] d; logic t, a;
    mwrite(32, PHY, 5'h04, 16'h8001);
    mread(32, PHY, 5'h04, d, t, a);
    chk("R6 turnaround and release", {15'd0, t}, 16'd1);
    chk("R6 msb first data", d, 16'h8001);
  endtask

  task automatic t_no_preamble;
    mwrite(0, PHY, 5'h00, 16'hA5C3);
    rd_chk("R3 no preamble back to back", 5'h00, 16'hA5C3, 0);
    rd_chk("R3 full preamble", 5'h00, 16'hA5C3, 32);
  endtask

  task automatic t_masks;
    mwrite(32, PHY, 5'h1B, 16'hFFFF);
    rd_chk("R7 irq reg write mask", 5'h1B, 16'h0E00);
    mwrite(32, PHY, 5'h1F, 16'hFFFF);
    rd_chk("R7 vendor write mask", 5'h1F, 16'h0200);
    mwrite(32, PHY, 5'h07, 16'h1234);
    rd_chk("R7 unmapped reads zero", 5'h07, 16'h0000);
    mwrite(32, PHY, 5'h1F, 16'h0000);
    mwrite(32, PHY, 5'h1B, 16'h0000);
  endtask

  task automatic t_mismatch;
    logic [15:0] d; logic t, a;
    mread(32, 5'h0C, 5'h00, d, t, a);
    chk("R5 other address never drives", {15'd0, a}, 16'd0);
    mwrite(32, 5'h0C, 5'h00, 16'h1111);
    mwrite(32, PHY, 5'h00, 16'h2222, 2'b11);
    mwrite(32, PHY, 5'h00, 16'h3333, 2'b00);
    rd_chk("R5 register untouched", 5'h00, 16'hA5C3);
  endtask

  task automatic t_strap;
    logic [15:0] d; logic t, a;
    strap = 5'h03;
    repeat (4) @(negedge clk);
    mread(32, 5'h03, 5'h00, d, t, a);
    chk("R4 new strap ignored", {15'd0, a}, 16'd0);
    rd_chk("R4 latched address answers", 5'h00, 16'hA5C3);
  endtask

  task automatic t_irq;
    mwrite(32, PHY, 5'h1B, 16'h0E00);
    chk("R9 idle active low", {15'd0, irq}, 16'd1);
    pulse(0);
    chk("R9 pending active low", {15'd0, irq}, 16'd0);
    rd_chk("R8 read returns link down", 5'h1B, 16'h0E04);
    chk("R8 read cleared irq", {15'd0, irq}, 16'd1);
    rd_chk("R8 cleared after read", 5'h1B, 16'h0E00);
    mwrite(32, PHY, 5'h1F, 16'h0200);
    chk("R9 idle active high", {15'd0, irq}, 16'd0);
    pulse(1);
    chk("R9 pending active high", {15'd0, irq}, 16'd1);
    mwrite(32, PHY, 5'h1B, 16'h0000);
    chk("R9 disabled masks", {15'd0, irq}, 16'd0);
    rd_chk("R8 remote fault latched", 5'h1B, 16'h0002);
    pulse(2);
    rd_chk("R8 partner ack latched", 5'h1B, 16'h0008);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_status_ro();
    t_read_timing();
    t_no_preamble();
    t_masks();
    t_mismatch();
    t_strap();
    t_irq();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule